// File: doc/BRIEF.md
# FIFO-Level DMA Request Generator

This block sits beside the transmit and receive FIFOs of a serial bus controller and decides when each FIFO should ask a DMA engine for service. Software programs three 16-bit registers over a small synchronous register bus:

- a control register that holds one enable bit per direction;
- a transmit level register;
- a receive level register.

The block compares the live FIFO occupancy counts against the programmed levels. It drives one registered request line per direction.

The two directions use opposite thresholds:

- **Transmit** wants refilling. It requests while its FIFO holds no more entries than the programmed level.
- **Receive** wants draining. It requests once its FIFO holds more entries than the programmed level, that is, at least the level plus one.

With the reset values:

- a receive request appears as soon as one entry is waiting and the receive enable is set;
- a transmit request appears only for an empty FIFO, and only when the transmit enable is set.

Top module: `dmareq_gen`

## Requirements
- R1: After reset, all three registers read 0 and both request outputs are 0.
- R2: The control register is at byte offset 0x088. Bit 1 is the transmit enable and bit 0 is the receive enable. Both are read/write.
- R3: The transmit level register is at offset 0x08C. It holds a read/write 3-bit level in bits 2:0.
- R4: The receive level register is at offset 0x090. It holds a read/write 3-bit level in bits 2:0.
- R5: Reserved bits are ignored on write and read back as 0. These are bits 15:2 of the control register and bits 15:3 of both level registers.
- R6: Any other address reads as 0, and a write to it changes no register.
- R7: The transmit request is 1 exactly when the transmit enable is 1 and the unsigned 4-bit transmit count is less than or equal to the transmit level. It follows its inputs with one clock of latency.
- R8: The receive request is 1 exactly when the receive enable is 1 and the unsigned 4-bit receive count is greater than or equal to the receive level plus one. It follows its inputs with one clock of latency.
- R9: Once an enable bit is cleared, its request is 0 on the next clock edge, whatever the FIFO count.
- R10: Read data is registered. It shows the register selected by the address one clock after the address is presented. A write is visible to a read issued in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| tx_count | input | 4 | Transmit FIFO occupancy (0 to 8) |
| rx_count | input | 4 | Receive FIFO occupancy (0 to 8) |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
Each direction's comparison is swept over every level from 0 to 7 and every count from 0 to 8, with the enable both set and cleared. This sweep separates the inclusive transmit bound from the level-plus-one receive bound, and it catches an off-by-one or a swapped comparison at each edge. It also exposes an enable that fails to gate the request.

Register access is tried with three kinds of write data:

- all-ones data, which separates stored bits from reserved bits;
- data aimed at an unmapped address, which shows that decoding is exact;
- an enable cleared while the count still meets the threshold, which isolates the deassertion path.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;

  localparam int unsigned REG_W   = 16;
  localparam int unsigned LEVEL_W = 3;

  localparam logic [11:0] OFS_CTRL  = 12'h088;
  localparam logic [11:0] OFS_TXLVL = 12'h08C;
  localparam logic [11:0] OFS_RXLVL = 12'h090;

  localparam int unsigned CTRL_TXEN_BIT = 1;
  localparam int unsigned CTRL_RXEN_BIT = 0;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_TXLVL = 2'd2,
    SEL_RXLVL = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [11:0] addr);
    reg_sel_e sel;
    sel = SEL_NONE;
    if (addr == OFS_CTRL)  sel = SEL_CTRL;
    if (addr == OFS_TXLVL) sel = SEL_TXLVL;
    if (addr == OFS_RXLVL) sel = SEL_RXLVL;
    return sel;
  endfunction

endpackage

// File: rtl/dmareq_rst_sync.sv
module dmareq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dmareq_regs.sv
module dmareq_regs
  import dmareq_pkg::*;
#(
  parameter int unsigned LVL_W = LEVEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  reg_sel_e         wsel,
  input  logic             wr,
  input  logic [LVL_W-1:0] wdata_lo,
  output logic             tx_en,
  output logic             rx_en,
  output logic [LVL_W-1:0] tx_lvl,
  output logic [LVL_W-1:0] rx_lvl
);

  logic             ld_ctrl, ld_tx, ld_rx;
  logic             tx_en_d, rx_en_d;
  logic [LVL_W-1:0] tx_lvl_d, rx_lvl_d;

  always_comb begin
    ld_ctrl  = wr && (wsel == SEL_CTRL);
    ld_tx    = wr && (wsel == SEL_TXLVL);
    ld_rx    = wr && (wsel == SEL_RXLVL);
    tx_en_d  = wdata_lo[CTRL_TXEN_BIT];
    rx_en_d  = wdata_lo[CTRL_RXEN_BIT];
    tx_lvl_d = wdata_lo;
    rx_lvl_d = wdata_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en <= 1'b0;
      rx_en <= 1'b0;
    end else if (ld_ctrl) begin
      tx_en <= tx_en_d;
      rx_en <= rx_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tx_lvl <= '0;
    else if (ld_tx) tx_lvl <= tx_lvl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rx_lvl <= '0;
    else if (ld_rx) rx_lvl <= rx_lvl_d;
  end

endmodule

// File: rtl/dmareq_rdmux.sv
module dmareq_rdmux
  import dmareq_pkg::*;
#(
  parameter int unsigned DATA_W = REG_W,
  parameter int unsigned LVL_W  = LEVEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  reg_sel_e          rsel,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic [LVL_W-1:0]  tx_lvl,
  input  logic [LVL_W-1:0]  rx_lvl,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    unique case (rsel)
      SEL_CTRL: begin
        rdata_d[CTRL_TXEN_BIT] = tx_en;
        rdata_d[CTRL_RXEN_BIT] = rx_en;
      end
      SEL_TXLVL: rdata_d[LVL_W-1:0] = tx_lvl;
      SEL_RXLVL: rdata_d[LVL_W-1:0] = rx_lvl;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end

endmodule

// File: rtl/dmareq_thresh.sv
module dmareq_thresh #(
  parameter int unsigned LVL_W   = 3,
  parameter int unsigned CNT_W   = 4,
  parameter bit          RX_SIDE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LVL_W-1:0] lvl,
  input  logic [CNT_W-1:0] cnt,
  output logic             req
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] lvl_ext;
  logic             hit;
  logic             req_d;

  assign lvl_ext = CNT_W'(lvl);

  generate
    if (RX_SIDE) begin : g_drain
      assign hit = (cnt >= (lvl_ext + ONE));
    end else begin : g_fill
      assign hit = (cnt <= lvl_ext);
    end
  endgenerate

  always_comb begin
    req_d = en && hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= req_d;
  end

endmodule

// File: rtl/dmareq_gen.sv
module dmareq_gen
  import dmareq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = REG_W,
  parameter int unsigned LVL_W  = LEVEL_W,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic [CNT_W-1:0]  rx_count,
  output logic              tx_dma_req,
  output logic              rx_dma_req
);

  logic             rst_sync_n;
  reg_sel_e         sel;
  logic             tx_en, rx_en;
  logic [LVL_W-1:0] tx_lvl, rx_lvl;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:LVL_W];
  assign sel = decode_addr(12'(bus_addr));

  dmareq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dmareq_regs #(.LVL_W(LVL_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wsel     (sel),
    .wr       (bus_wr),
    .wdata_lo (bus_wdata[LVL_W-1:0]),
    .tx_en    (tx_en),
    .rx_en    (rx_en),
    .tx_lvl   (tx_lvl),
    .rx_lvl   (rx_lvl)
  );

  dmareq_rdmux #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_rdmux (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .rsel   (sel),
    .tx_en  (tx_en),
    .rx_en  (rx_en),
    .tx_lvl (tx_lvl),
    .rx_lvl (rx_lvl),
    .rdata  (bus_rdata)
  );

  dmareq_thresh #(.LVL_W(LVL_W), .CNT_W(CNT_W), .RX_SIDE(1'b0)) u_tx_thr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (tx_en),
    .lvl   (tx_lvl),
    .cnt   (tx_count),
    .req   (tx_dma_req)
  );

  dmareq_thresh #(.LVL_W(LVL_W), .CNT_W(CNT_W), .RX_SIDE(1'b1)) u_rx_thr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (rx_en),
    .lvl   (rx_lvl),
    .cnt   (rx_count),
    .req   (rx_dma_req)
  );

endmodule

// File: rtl/dmareq_gen_chk.sv
module dmareq_gen_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [CNT_W-1:0]  tx_count,
  input logic [CNT_W-1:0]  rx_count,
  input logic              tx_en,
  input logic              rx_en,
  input logic [LVL_W-1:0]  tx_lvl,
  input logic [LVL_W-1:0]  rx_lvl,
  input logic              tx_dma_req,
  input logic              rx_dma_req
);

  logic mapped;
  assign mapped = (bus_addr == ADDR_W'(12'h088)) || (bus_addr == ADDR_W'(12'h08C)) ||
                  (bus_addr == ADDR_W'(12'h090));

  // R7
  a_r7_tx_threshold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (tx_dma_req == ($past(tx_en) && ($past(tx_count) <= CNT_W'($past(tx_lvl))))));

  // R8
  a_r8_rx_threshold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (rx_dma_req == ($past(rx_en) && ($past(rx_count) > CNT_W'($past(rx_lvl))))));

  // R9
  a_r9_tx_gate: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tx_en |=> !tx_dma_req);

  a_r9_rx_gate: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rx_en |=> !rx_dma_req);

  // R5
  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_rdata[DATA_W-1:LVL_W] == '0);

  // R6
  a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mapped |=> (bus_rdata == '0));

endmodule

bind dmareq_gen dmareq_gen_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .tx_count   (tx_count),
  .rx_count   (rx_count),
  .tx_en      (tx_en),
  .rx_en      (rx_en),
  .tx_lvl     (tx_lvl),
  .rx_lvl     (rx_lvl),
  .tx_dma_req (tx_dma_req),
  .rx_dma_req (rx_dma_req)
);

// File: tb/dmareq_gen_tb.sv
module dmareq_gen_tb;

  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [3:0]  tx_count;
  logic [3:0]  rx_count;
  logic        tx_dma_req;
  logic        rx_dma_req;

  int n_cmp;
  int n_bad;
  bit done;

  dmareq_gen u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .tx_count   (tx_count),
    .rx_count   (rx_count),
    .tx_dma_req (tx_dma_req),
    .rx_dma_req (rx_dma_req)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_wr   = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    logic [15:0] v;
    n_cmp = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    tx_count = '0; rx_count = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 tx_req", {15'd0, tx_dma_req}, 16'd0);
    check("R1 rx_req", {15'd0, rx_dma_req}, 16'd0);
    rd(12'h088, v); check("R1 ctrl", v, 16'h0000);
    rd(12'h08C, v); check("R1 txlvl", v, 16'h0000);
    rd(12'h090, v); check("R1 rxlvl", v, 16'h0000);

    // R2, R5: all-ones to control keeps only the two enables
    wr(12'h088, 16'hFFFF); rd(12'h088, v); check("R2/R5 ctrl", v, 16'h0003);
    wr(12'h088, 16'h0002); rd(12'h088, v); check("R2 ctrl txen only", v, 16'h0002);
    wr(12'h088, 16'h0001); rd(12'h088, v); check("R2 ctrl rxen only", v, 16'h0001);
    // R3, R4, R5
    wr(12'h08C, 16'hFFF5); rd(12'h08C, v); check("R3/R5 txlvl", v, 16'h0005);
    wr(12'h090, 16'hABCE); rd(12'h090, v); check("R4/R5 rxlvl", v, 16'h0006);
    // R6: unmapped read and write
    wr(12'h094, 16'hFFFF); rd(12'h094, v); check("R6 unmapped read", v, 16'h0000);
    wr(12'h08A, 16'h0000); rd(12'h084, v); check("R6 unmapped read2", v, 16'h0000);
    rd(12'h088, v); check("R6 ctrl intact", v, 16'h0001);
    rd(12'h08C, v); check("R6 txlvl intact", v, 16'h0005);
    rd(12'h090, v); check("R6 rxlvl intact", v, 16'h0006);
    // R10: write then immediate read of new value
    wr(12'h090, 16'h0000); rd(12'h090, v); check("R10 read after write", v, 16'h0000);

    // R7, R8 sweeps
    for (int en = 0; en < 2; en++) begin
      for (int lvl = 0; lvl < 8; lvl++) begin
        wr(12'h088, en[0] ? 16'h0003 : 16'h0000);
        wr(12'h08C, 16'(lvl));
        wr(12'h090, 16'(lvl));
        for (int c = 0; c < 9; c++) begin
          tx_count = 4'(c);
          rx_count = 4'(c);
          @(negedge clk);
          check("R7 tx sweep", {15'd0, tx_dma_req}, {15'd0, (en == 1) && (c <= lvl)});
          check("R8 rx sweep", {15'd0, rx_dma_req}, {15'd0, (en == 1) && (c >= lvl + 1)});
        end
      end
    end

    // R9: clear enables while thresholds are met
    wr(12'h08C, 16'h0007); wr(12'h090, 16'h0000);
    wr(12'h088, 16'h0003);
    tx_count = 4'd2; rx_count = 4'd5;
    @(negedge clk);
    check("R9 tx pre", {15'd0, tx_dma_req}, 16'd1);
    check("R9 rx pre", {15'd0, rx_dma_req}, 16'd1);
    wr(12'h088, 16'h0001);
    @(negedge clk);
    check("R9 tx cleared", {15'd0, tx_dma_req}, 16'd0);
    check("R9 rx kept", {15'd0, rx_dma_req}, 16'd1);
    wr(12'h088, 16'h0000);
    @(negedge clk);
    check("R9 rx cleared", {15'd0, rx_dma_req}, 16'd0);

    // R8 reset-level behaviour: one entry triggers
    wr(12'h088, 16'h0001); rx_count = 4'd1;
    @(negedge clk);
    check("R8 one entry", {15'd0, rx_dma_req}, 16'd1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule